// File: doc/BRIEF.md
# Square-Wave Dwell Error Evaluator

This block scores how closely one binary signal behaves like a square wave of a chosen period, within an observation window of fixed length. After a start pulse it counts clock cycles. It stamps each logic change of the signal with the current count. Each time the signal leaves a level, the block compares how long it stayed there with a target half-period and adds the absolute difference to a running error sum. The moment of start and the last cycle of the window are both treated as level changes. The first interval therefore runs from start to the first change, and the last interval runs from the final change to the window end.

When the window closes, the block divides the error sum by the number of intervals to give an average error per dwell. It then forms a fixed-point fitness value equal to the reciprocal of that average. A trial can also end early, and marked as aborted, when the signal plainly cannot score well. This happens when it changes level more often than a set limit, or stays at one level longer than a set timeout. A typical use is to rank many candidate oscillator circuits against a target frequency, such as 1 kHz, where each level should last 0.5 ms.

Top module: `dwell_err_eval`

## Requirements
- R1: After reset, `done_o` and `aborted_o` are 0, and `err_sum_o`, `interval_cnt_o`, `avg_err_o` and `fitness_o` are all 0.
- R2: `sig_i` passes through a two-stage synchronizer. If `sig_i` changes level before the k-th rising edge that follows the edge at which `start_i` was taken, the change is stamped with time k+1. The window opens at time 0 and closes at time `window_len_i` (at least 1). A change stamped at time 0 is not counted.
- R3: Every interval adds |interval length − `half_period_i`| to `err_sum_o`. An interval runs between consecutive stamps, with the window opening and closing counted as stamps.
- R4: When the window closes, the final interval (last change to `window_len_i`) is included, and `interval_cnt_o` equals the number of counted changes plus one. A signal that never changes gives one interval equal to the whole window.
- R5: After a window closes normally, `avg_err_o` = floor(`err_sum_o` / `interval_cnt_o`).
- R6: After a normal close, `fitness_o` = floor(2^FRAC / `avg_err_o`), saturated to the all-ones value of its width. An average of 0 gives the all-ones value.
- R7: Suppose a counted change raises the number of changes above `max_edges_i`. The trial then aborts at that change: its interval is still added, `done_o` and `aborted_o` go to 1, and `avg_err_o` and `fitness_o` are 0.
- R8: Suppose `idle_limit_i` cycles pass after the last stamp with no change, before the window closes. The trial then aborts without adding the unfinished interval, and `done_o` and `aborted_o` go to 1, with `avg_err_o` and `fitness_o` at 0. A change that arrives exactly `idle_limit_i` cycles after the last stamp keeps the trial alive.
- R9: `start_i` is ignored while a trial or its division is in progress. The configuration inputs are captured when a start is taken, so changing them during a trial has no effect on its result.
- R10: Results and `done_o` stay unchanged until the next accepted start. That start clears `done_o`, `aborted_o` and all result outputs at the edge where it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a trial (taken only when idle or finished) |
| sig_i | input | 1 | Asynchronous signal under evaluation |
| half_period_i | input | TW | Target dwell per level, in cycles |
| window_len_i | input | TW | Window length in cycles |
| max_edges_i | input | CW | Largest number of changes allowed before abort |
| idle_limit_i | input | TW | Cycles without a change that cause abort |
| err_sum_o | output | TW+CW+1 | Sum of absolute dwell errors |
| interval_cnt_o | output | CW+1 | Number of intervals summed |
| avg_err_o | output | TW+CW+1 | Average error per interval |
| fitness_o | output | FIT_W | Reciprocal of average error, fixed point |
| done_o | output | 1 | Trial finished, results valid |
| aborted_o | output | 1 | Trial ended early |

## Verification
The block is driven with several kinds of signal:
- A signal toggling exactly on target separates the saturated-fitness path from ordinary division.
- A regularly slow signal shows that the error is taken per dwell, and that the closing interval is added.
- A silent signal confirms that the window edges alone form one interval.
- A signal giving an average of exactly one hits the fitness saturation point.
- A toggle storm and a signal that stalls exercise the two abort rules.
- A run held exactly at the change limit and the idle limit shows that both limits are inclusive.

Directed runs cover the reset state, a start pulse and configuration change made mid-trial, and holding and clearing of results.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_AVG,
    ST_FIT,
    ST_FIN
  } eval_state_t;

endpackage

// File: rtl/dwell_sync.sv
module dwell_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dwell_tracker.sv
module dwell_tracker #(
  parameter int TW   = 24,
  parameter int CW   = 16,
  parameter int EW   = 41,
  parameter int CNTW = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            lvl_i,
  input  logic [TW-1:0]   half_i,
  input  logic [TW-1:0]   win_i,
  input  logic [CW-1:0]   maxe_i,
  input  logic [TW-1:0]   idle_i,
  output logic            closed_o,
  output logic            abort_o,
  output logic [EW-1:0]   err_o,
  output logic [CNTW-1:0] cnt_o
);

  logic            run_q, prev_q;
  logic [TW-1:0]   t_q, mark_q, hp_q, win_q, idle_q;
  logic [CW-1:0]   max_q;
  logic [CNTW-1:0] edges_q, cnt_q;
  logic [EW-1:0]   err_q;

  logic [TW-1:0]   gap, dev;
  logic [CNTW-1:0] edges_nx;
  logic            at_end, edge_v, over;

  always_comb begin
    gap      = t_q - mark_q;
    dev      = (gap >= hp_q) ? (gap - hp_q) : (hp_q - gap);
    at_end   = run_q && (t_q == win_q);
    edge_v   = run_q && !at_end && (t_q != '0) && (lvl_i != prev_q);
    edges_nx = edges_q + 1'b1;
    over     = edges_nx > CNTW'(max_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      prev_q   <= 1'b0;
      t_q      <= '0;
      mark_q   <= '0;
      hp_q     <= '0;
      win_q    <= '0;
      idle_q   <= '0;
      max_q    <= '0;
      edges_q  <= '0;
      cnt_q    <= '0;
      err_q    <= '0;
      closed_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      closed_o <= 1'b0;
      abort_o  <= 1'b0;
      if (start_i) begin
        run_q   <= 1'b1;
        t_q     <= '0;
        mark_q  <= '0;
        edges_q <= '0;
        cnt_q   <= '0;
        err_q   <= '0;
        hp_q    <= half_i;
        win_q   <= win_i;
        idle_q  <= idle_i;
        max_q   <= maxe_i;
      end else if (run_q) begin
        t_q <= t_q + 1'b1;
        if (at_end) begin
          err_q    <= err_q + EW'(dev);
          cnt_q    <= cnt_q + 1'b1;
          run_q    <= 1'b0;
          closed_o <= 1'b1;
        end else if (edge_v) begin
          err_q   <= err_q + EW'(dev);
          cnt_q   <= cnt_q + 1'b1;
          edges_q <= edges_nx;
          mark_q  <= t_q;
          if (over) begin
            run_q   <= 1'b0;
            abort_o <= 1'b1;
          end
        end else if (gap >= idle_q) begin
          run_q   <= 1'b0;
          abort_o <= 1'b1;
        end
      end
    end
  end

  assign err_o = err_q;
  assign cnt_o = cnt_q;

  p_mark_not_ahead_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (mark_q <= t_q));

  p_single_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    !(closed_o && abort_o));

  p_edge_cap_r7: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (edges_q <= CNTW'(max_q)));

  p_window_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (t_q <= win_q));

endmodule

// File: rtl/dwell_divider.sv
module dwell_divider #(
  parameter int N = 41
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [N-1:0] num_i,
  input  logic [N-1:0] den_i,
  output logic [N-1:0] quo_o,
  output logic         valid_o
);

  localparam int SW = $clog2(N + 1);

  logic [N-1:0]  rem_q, quo_q, den_q;
  logic [SW-1:0] step_q;
  logic          busy_q;
  logic [N:0]    shifted, trial;

  always_comb begin
    shifted = {rem_q, quo_q[N-1]};
    trial   = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
      busy_q  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        den_q  <= den_i;
        step_q <= SW'(N);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!trial[N]) begin
          rem_q <= trial[N-1:0];
          quo_q <= {quo_q[N-2:0], 1'b1};
        end else begin
          rem_q <= shifted[N-1:0];
          quo_q <= {quo_q[N-2:0], 1'b0};
        end
        step_q <= step_q - 1'b1;
        if (step_q == SW'(1)) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;

  p_rem_below_den_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (rem_q < den_q));

endmodule

// File: rtl/dwell_err_eval.sv
module dwell_err_eval
  import dwell_pkg::*;
#(
  parameter int  TW    = 24,
  parameter int  CW    = 16,
  parameter int  FRAC  = 16,
  parameter int  FIT_W = 16,
  localparam int EW    = TW + CW + 1,
  localparam int CNTW  = CW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sig_i,
  input  logic [TW-1:0]    half_period_i,
  input  logic [TW-1:0]    window_len_i,
  input  logic [CW-1:0]    max_edges_i,
  input  logic [TW-1:0]    idle_limit_i,
  output logic [EW-1:0]    err_sum_o,
  output logic [CNTW-1:0]  interval_cnt_o,
  output logic [EW-1:0]    avg_err_o,
  output logic [FIT_W-1:0] fitness_o,
  output logic             done_o,
  output logic             aborted_o
);

  localparam logic [FIT_W-1:0] FIT_MAX = {FIT_W{1'b1}};
  localparam logic [EW-1:0]    FIT_NUM = EW'(1) << FRAC;

  eval_state_t     state_q;
  logic            lvl, accept;
  logic            trk_closed, trk_abort;
  logic [EW-1:0]   trk_err;
  logic [CNTW-1:0] trk_cnt;
  logic            div_go, div_valid;
  logic [EW-1:0]   div_num, div_den, div_quo;

  dwell_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (sig_i),
    .sync_o  (lvl)
  );

  assign accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_FIN));

  dwell_tracker #(.TW(TW), .CW(CW), .EW(EW), .CNTW(CNTW)) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .start_i  (accept),
    .lvl_i    (lvl),
    .half_i   (half_period_i),
    .win_i    (window_len_i),
    .maxe_i   (max_edges_i),
    .idle_i   (idle_limit_i),
    .closed_o (trk_closed),
    .abort_o  (trk_abort),
    .err_o    (trk_err),
    .cnt_o    (trk_cnt)
  );

  always_comb begin
    div_go  = 1'b0;
    div_num = trk_err;
    div_den = EW'(trk_cnt);
    if (state_q == ST_RUN) begin
      div_go = trk_closed;
    end else if (state_q == ST_AVG) begin
      div_go  = div_valid && (div_quo != '0);
      div_num = FIT_NUM;
      div_den = div_quo;
    end
  end

  dwell_divider #(.N(EW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go_i    (div_go),
    .num_i   (div_num),
    .den_i   (div_den),
    .quo_o   (div_quo),
    .valid_o (div_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      err_sum_o      <= '0;
      interval_cnt_o <= '0;
      avg_err_o      <= '0;
      fitness_o      <= '0;
      done_o         <= 1'b0;
      aborted_o      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            state_q        <= ST_RUN;
            err_sum_o      <= '0;
            interval_cnt_o <= '0;
            avg_err_o      <= '0;
            fitness_o      <= '0;
            done_o         <= 1'b0;
            aborted_o      <= 1'b0;
          end
        end
        ST_RUN: begin
          if (trk_abort) begin
            err_sum_o      <= trk_err;
            interval_cnt_o <= trk_cnt;
            done_o         <= 1'b1;
            aborted_o      <= 1'b1;
            state_q        <= ST_FIN;
          end else if (trk_closed) begin
            err_sum_o      <= trk_err;
            interval_cnt_o <= trk_cnt;
            state_q        <= ST_AVG;
          end
        end
        ST_AVG: begin
          if (div_valid) begin
            avg_err_o <= div_quo;
            if (div_quo == '0) begin
              fitness_o <= FIT_MAX;
              done_o    <= 1'b1;
              state_q   <= ST_FIN;
            end else begin
              state_q <= ST_FIT;
            end
          end
        end
        ST_FIT: begin
          if (div_valid) begin
            fitness_o <= (div_quo > EW'(FIT_MAX)) ? FIT_MAX : div_quo[FIT_W-1:0];
            done_o    <= 1'b1;
            state_q   <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_abort_sets_done_r7: assert property (@(posedge clk) disable iff (rst)
    aborted_o |-> done_o);

  p_zero_avg_saturates_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !aborted_o && (avg_err_o == '0)) |-> (fitness_o == FIT_MAX));

  p_results_held_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> ($stable(err_sum_o) && $stable(fitness_o) && done_o));

  p_abort_zero_score_r8: assert property (@(posedge clk) disable iff (rst)
    aborted_o |-> ((fitness_o == '0) && (avg_err_o == '0)));

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_AVG) && start_i && !div_valid) |=> (state_q == ST_AVG));

endmodule

// File: tb/dwell_err_eval_bench.sv
`timescale 1ns/1ps
module dwell_err_eval_bench;

  localparam int  TW = 24, CW = 16, FRAC = 16, FIT_W = 16;
  localparam int  EW = TW + CW + 1, CNTW = CW + 1;
  localparam longint FMAX = (64'd1 << FIT_W) - 1;

  typedef struct packed {
    int hp; int win; int first; int gap; int n; int maxe; int idle;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{10, 100,  9, 10,  9, 50, 1000},  // on target
    '{10, 100, 11, 12,  7, 50, 1000},  // steadily slow
    '{10,  50,  0,  1,  0, 50, 1000},  // silent
    '{20, 200,  3,  2, 50,  5, 1000},  // storm
    '{10, 200,  9, 10,  3, 50,   30},  // stalls
    '{10,  22, 10, 10,  1, 50, 1000},  // average of one
    '{10, 100,  9, 10,  9,  9,   10}   // both limits reached exactly
  };

  logic             clk = 1'b0, rst = 1'b1, start = 1'b0, sig = 1'b0;
  logic [TW-1:0]    hp = '0, win = '0, idle = '0;
  logic [CW-1:0]    maxe = '0;
  logic [EW-1:0]    err_sum, avg_err;
  logic [CNTW-1:0]  icnt;
  logic [FIT_W-1:0] fit;
  logic             done, aborted;

  int applied = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  dwell_err_eval u_dwell_err_eval (
    .clk (clk), .rst (rst), .start_i (start), .sig_i (sig),
    .half_period_i (hp), .window_len_i (win), .max_edges_i (maxe),
    .idle_limit_i (idle), .err_sum_o (err_sum), .interval_cnt_o (icnt),
    .avg_err_o (avg_err), .fitness_o (fit), .done_o (done), .aborted_o (aborted)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung (got %0d cycles, expected fewer)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    applied++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model(input vec_t v, output longint e_err, output longint e_cnt,
                       output longint e_avg, output longint e_fit, output bit e_ab);
    longint mark, ts, d, edges;
    mark = 0; e_err = 0; e_cnt = 0; edges = 0; e_ab = 0;
    for (int i = 0; i < v.n; i++) begin
      ts = v.first + i * v.gap + 1;
      if (ts >= v.win) break;
      if (ts - mark > v.idle) begin e_ab = 1; break; end
      d = ts - mark - v.hp; if (d < 0) d = -d;
      e_err += d; e_cnt++; edges++; mark = ts;
      if (edges > v.maxe) begin e_ab = 1; break; end
    end
    if (!e_ab) begin
      if (v.win - mark > v.idle) e_ab = 1;
      else begin
        d = v.win - mark - v.hp; if (d < 0) d = -d;
        e_err += d; e_cnt++;
      end
    end
    if (e_ab) begin e_avg = 0; e_fit = 0; end
    else begin
      e_avg = e_err / e_cnt;
      if (e_avg == 0) e_fit = FMAX;
      else begin
        e_fit = (64'd1 << FRAC) / e_avg;
        if (e_fit > FMAX) e_fit = FMAX;
      end
    end
  endtask

  function automatic bit toggles_at(vec_t v, int k);
    return (v.n > 0) && (k >= v.first) && ((k - v.first) % v.gap == 0)
           && ((k - v.first) / v.gap < v.n);
  endfunction

  task automatic run_vec(input vec_t v, input bit disturb);
    sig = 1'b0;
    repeat (4) @(negedge clk);
    hp = TW'(v.hp); win = TW'(v.win); maxe = CW'(v.maxe); idle = TW'(v.idle);
    start = 1'b1;
    for (int k = 1; k <= v.win + 2; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (toggles_at(v, k)) sig = ~sig;
      if (disturb && k == 5) begin start = 1'b1; win = TW'(3); hp = '0; idle = TW'(1); end
      if (disturb && k == 6) start = 1'b0;
    end
    for (int w = 0; w < 400 && !done; w++) @(negedge clk);
    hp = '0; win = '0; idle = '0; maxe = '0;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    longint e_err, e_cnt, e_avg, e_fit; bit e_ab;
    model(v, e_err, e_cnt, e_avg, e_fit, e_ab);
    chk({tag, " R3 err_sum"}, longint'(err_sum), e_err);
    chk({tag, " R4 interval_cnt"}, longint'(icnt), e_cnt);
    chk({tag, " R5 avg_err"}, longint'(avg_err), e_avg);
    chk({tag, " R6 fitness"}, longint'(fit), e_fit);
    chk({tag, " R7/R8 aborted"}, longint'(aborted), longint'(e_ab));
    chk({tag, " R10 done"}, longint'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", longint'(done), 0);
    chk("R1 aborted", longint'(aborted), 0);
    chk("R1 err_sum", longint'(err_sum), 0);
    chk("R1 interval_cnt", longint'(icnt), 0);
    chk("R1 fitness", longint'(fit), 0);

    // table walk; stamps follow the R2 timing rule inside the model
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], 1'b0);
      check_vec(VECS[i], $sformatf("R2 vec%0d", i));
    end

    // R9: a start pulse and new configuration mid-trial change nothing
    run_vec(VECS[1], 1'b1);
    check_vec(VECS[1], "R9 disturbed");

    // R10: results held while idle, cleared by the next start
    repeat (20) @(negedge clk);
    check_vec(VECS[1], "R10 held");
    win = TW'(50); hp = TW'(10); idle = TW'(1000); maxe = CW'(50);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done cleared", longint'(done), 0);
    chk("R10 err cleared", longint'(err_sum), 0);
    chk("R10 fitness cleared", longint'(fit), 0);
    for (int w = 0; w < 400 && !done; w++) @(negedge clk);
    check_vec(VECS[2], "R4 silent rerun");

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule